// File: doc/BRIEF.md
# Multichannel Wiper Register Bank with Emulated Nonvolatile Copy

This block keeps the tap settings of a multichannel digitally controlled resistor. Every channel carries three registers: a staging register that a command fills, the live wiper register that sets the tap, and a copy standing in for nonvolatile memory. New settings wait in the staging register until a load strobe moves them to the wiper, either for one chosen channel or for every channel in the same cycle. Commands save a wiper into its nonvolatile copy, restore one or all wipers from those copies, and step every wiper up or down together with saturation.

A write-protect input freezes the live wipers and the nonvolatile copies against loads, steps and saves, but restores from the nonvolatile copies still go through. A hardware preset input overrides everything and copies the nonvolatile values into all wipers. A save models a slow memory write: the ready output drops for a parameterised number of cycles, and commands or loads that arrive meanwhile are dropped. At reset, both the wipers and the nonvolatile copies start at midscale, so the two wiper-to-end resistances are equal.

Top module: `wiper_bank`

## Requirements
- R1: After reset every wiper equals midscale (2^(W-1)) and ready_o is high.
- R2: Command code 1 writes cmd_data_i into the staging register of channel cmd_ch_i and changes no wiper; a load strobe (load_i high, load_all_i low) copies the staging register of channel load_ch_i into that wiper only, on the next clock edge.
- R3: A load strobe with load_all_i high copies every channel's staging register into its wiper in the same edge.
- R4: Code 5 raises and code 6 lowers every wiper by one; a wiper at full scale (2^W-1) stays there on a raise, and a wiper at zero stays there on a lower.
- R5: Code 2 saves the wiper of channel cmd_ch_i into its nonvolatile copy; ready_o goes low on the following edge and stays low for exactly NV_WR_CYCLES cycles.
- R6: While ready_o is low, commands and load strobes have no effect.
- R7: While wp_i is high, load strobes, codes 5 and 6 and code 2 have no effect; code 1 still writes the staging register.
- R8: Code 3 copies the nonvolatile value of channel cmd_ch_i into its wiper and code 4 does so for every channel, whether or not wp_i is high.
- R9: While preset_i is high, every wiper takes its nonvolatile value on each edge, regardless of wp_i, ready_o, commands or load strobes.
- R10: Codes 0 and 7 have no effect, and a command in a cycle where load_i or preset_i is high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 3 | Command code (0 none, 1 stage, 2 save, 3 restore one, 4 restore all, 5 raise all, 6 lower all, 7 reserved) |
| cmd_ch_i | input | CHW | Channel addressed by the command |
| cmd_data_i | input | W | Value for the staging register |
| load_i | input | 1 | Load strobe, staging to wiper |
| load_all_i | input | 1 | Load strobe targets all channels |
| load_ch_i | input | CHW | Channel for a single-channel load |
| wp_i | input | 1 | Write protect |
| preset_i | input | 1 | Hardware preset from nonvolatile copies |
| ready_o | output | 1 | High when a new command may be issued |
| wiper_o | output | N_CH*W | Wiper values, channel 0 in the low bits |

## Verification
The staging path is swept exhaustively: every value is staged into every channel, first checked as invisible on the wiper, then loaded and checked, which separates staging from loading and single from all-channel loads. Raise and lower run well past both ends to tell saturation from wrap-around. Saves, restores, write protect, preset and busy windows are mixed with conflicting loads and steps in the same cycles, so that each gating rule and priority is distinguished from its neighbours by the wiper values it leaves behind.

// File: rtl/wiper_bank_pkg.sv
package wiper_bank_pkg;
  typedef enum logic [2:0] {
    OP_NOP         = 3'd0,
    OP_STAGE       = 3'd1,
    OP_SAVE        = 3'd2,
    OP_RESTORE     = 3'd3,
    OP_RESTORE_ALL = 3'd4,
    OP_RAISE_ALL   = 3'd5,
    OP_LOWER_ALL   = 3'd6,
    OP_RSVD        = 3'd7
  } op_e;
endpackage

// File: rtl/wiper_busy_timer.sv
module wiper_busy_timer #(
  parameter int unsigned CYCLES = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= CMAX;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ready_o = (cnt_q == '0);

  assert_start_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ready_o);
  assert_no_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !start_i);
  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX);
endmodule

// File: rtl/wiper_chan.sv
module wiper_chan #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stage_we_i,
  input  logic [W-1:0] stage_d_i,
  input  logic         load_i,
  input  logic         restore_i,
  input  logic         save_i,
  input  logic         raise_i,
  input  logic         lower_i,
  output logic [W-1:0] wiper_o
);
  localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] FULL = '1;

  logic [W-1:0] stage_q, wip_q, nv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= MID;
      wip_q   <= MID;
      nv_q    <= MID;
    end else begin
      if (stage_we_i) stage_q <= stage_d_i;
      if (save_i)     nv_q    <= wip_q;
      // restore outranks load, load outranks stepping
      if (restore_i)                      wip_q <= nv_q;
      else if (load_i)                    wip_q <= stage_q;
      else if (raise_i && wip_q != FULL)  wip_q <= wip_q + 1'b1;
      else if (lower_i && wip_q != '0)    wip_q <= wip_q - 1'b1;
    end
  end

  assign wiper_o = wip_q;

  assert_sat_top_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raise_i && !restore_i && !load_i && wip_q == FULL) |=> wip_q == FULL);
  assert_sat_bot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lower_i && !restore_i && !load_i && !raise_i && wip_q == '0) |=> wip_q == '0);
  assert_restore_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> wip_q == $past(nv_q));
  assert_save_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_i |=> nv_q == $past(wip_q));
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
  import wiper_bank_pkg::*;
#(
  parameter int unsigned N_CH         = 4,
  parameter int unsigned W            = 8,
  parameter int unsigned NV_WR_CYCLES = 6,
  localparam int unsigned CHW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [CHW-1:0]    cmd_ch_i,
  input  logic [W-1:0]      cmd_data_i,
  input  logic              load_i,
  input  logic              load_all_i,
  input  logic [CHW-1:0]    load_ch_i,
  input  logic              wp_i,
  input  logic              preset_i,
  output logic              ready_o,
  output logic [N_CH*W-1:0] wiper_o
);
  op_e  op;
  logic cmd_go, load_go, save_go, raise_go, lower_go, restore_all_go, restore_one_go;

  assign op             = op_e'(cmd_op_i);
  assign cmd_go         = cmd_valid_i && ready_o && !load_i && !preset_i;
  assign load_go        = load_i && ready_o && !wp_i && !preset_i;
  assign save_go        = cmd_go && op == OP_SAVE && !wp_i;
  assign raise_go       = cmd_go && op == OP_RAISE_ALL && !wp_i;
  assign lower_go       = cmd_go && op == OP_LOWER_ALL && !wp_i;
  assign restore_all_go = preset_i || (cmd_go && op == OP_RESTORE_ALL);
  assign restore_one_go = cmd_go && op == OP_RESTORE;

  wiper_busy_timer #(.CYCLES(NV_WR_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (save_go),
    .ready_o (ready_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [CHW-1:0] CI = CHW'(c);
    logic hit_cmd, hit_load;
    assign hit_cmd  = (cmd_ch_i == CI);
    assign hit_load = load_all_i || (load_ch_i == CI);

    wiper_chan #(.W(W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .stage_we_i (cmd_go && op == OP_STAGE && hit_cmd),
      .stage_d_i  (cmd_data_i),
      .load_i     (load_go && hit_load),
      .restore_i  (restore_all_go || (restore_one_go && hit_cmd)),
      .save_i     (save_go && hit_cmd),
      .raise_i    (raise_go),
      .lower_i    (lower_go),
      .wiper_o    (wiper_o[c*W +: W])
    );
  end

  assert_busy_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !preset_i) |=> $stable(wiper_o));
  assert_wp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_i && !preset_i && !(cmd_valid_i && !load_i &&
      (cmd_op_i == 3'd3 || cmd_op_i == 3'd4))) |=> $stable(wiper_o));
  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!preset_i && !load_i && (!cmd_valid_i || cmd_op_i == 3'd0 || cmd_op_i == 3'd7))
      |=> $stable(wiper_o));
endmodule

// File: tb/sim_wiper_bank.sv
`timescale 1ns/1ps
module sim_wiper_bank;
  localparam int N = 4, W = 4, NV = 5, CHW = 2;
  localparam int MID = 8, FULL = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, load = 0, load_all = 0, wp = 0, preset = 0;
  logic [2:0] cmd_op = '0;
  logic [CHW-1:0] cmd_ch = '0, load_ch = '0;
  logic [W-1:0] cmd_data = '0;
  logic ready;
  logic [N*W-1:0] wiper;

  int checks = 0, fails = 0;
  int m_w[N], m_nv[N], m_in[N];
  int m_busy = 0;

  always #4 clk = ~clk;

  wiper_bank #(.N_CH(N), .W(W), .NV_WR_CYCLES(NV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_ch_i(cmd_ch), .cmd_data_i(cmd_data), .load_i(load), .load_all_i(load_all),
    .load_ch_i(load_ch), .wp_i(wp), .preset_i(preset), .ready_o(ready), .wiper_o(wiper));

  task automatic model_edge();
    bit rdy, cok, lok;
    int ch;
    rdy = (m_busy == 0);
    if (m_busy > 0) m_busy--;
    cok = cmd_valid && rdy && !load && !preset;
    lok = load && rdy && !wp && !preset;
    ch  = int'(cmd_ch);
    if (preset) for (int c = 0; c < N; c++) m_w[c] = m_nv[c];
    else if (lok) for (int c = 0; c < N; c++)
      if (load_all || c == int'(load_ch)) m_w[c] = m_in[c];
    if (cok) case (cmd_op)
      3'd1: m_in[ch] = int'(cmd_data);
      3'd2: if (!wp) begin m_nv[ch] = m_w[ch]; m_busy = NV; end
      3'd3: m_w[ch] = m_nv[ch];
      3'd4: for (int c = 0; c < N; c++) m_w[c] = m_nv[c];
      3'd5: if (!wp) for (int c = 0; c < N; c++) if (m_w[c] < FULL) m_w[c]++;
      3'd6: if (!wp) for (int c = 0; c < N; c++) if (m_w[c] > 0) m_w[c]--;
      default: ;
    endcase
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #2;
    cmd_valid = 0; load = 0; load_all = 0; preset = 0; cmd_op = '0;
  endtask

  task automatic check_state(input string tag);
    for (int c = 0; c < N; c++) begin
      checks++;
      if (int'(wiper[c*W +: W]) != m_w[c]) begin
        fails++;
        $display("FAIL %s ch%0d wiper actual %0d expected %0d", tag, c, wiper[c*W +: W], m_w[c]);
      end
    end
    checks++;
    if (ready !== (m_busy == 0)) begin
      fails++;
      $display("FAIL %s ready actual %0b expected %0b", tag, ready, (m_busy == 0));
    end
  endtask

  task automatic cmd(input int op, input int ch, input int d);
    cmd_valid = 1; cmd_op = 3'(op); cmd_ch = CHW'(ch); cmd_data = W'(d);
  endtask

  task automatic ld(input bit all, input int ch);
    load = 1; load_all = all; load_ch = CHW'(ch);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < N; c++) begin m_w[c] = MID; m_nv[c] = MID; m_in[c] = MID; end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    check_state("R1 reset");

    // R2: exhaustive staging then single-channel load
    for (int c = 0; c < N; c++)
      for (int v = 0; v <= FULL; v++) begin
        cmd(1, c, v); tick(); check_state("R2 stage no effect");
        ld(0, c);     tick(); check_state("R2 single load");
      end

    // R3: load all
    for (int c = 0; c < N; c++) begin cmd(1, c, 3 + 4*c); tick(); end
    ld(1, 0); tick(); check_state("R3 load all");

    // R4: saturation both ends
    for (int i = 0; i < 20; i++) begin cmd(5, 0, 0); tick(); check_state("R4 raise"); end
    for (int i = 0; i < 20; i++) begin cmd(6, 0, 0); tick(); check_state("R4 lower"); end
    for (int i = 0; i < 7; i++)  begin cmd(5, 0, 0); tick(); end
    check_state("R4 mid raise");

    // R5 / R6: save with busy window and ignored traffic
    cmd(2, 1, 0); tick(); check_state("R5 save start");
    for (int i = 0; i < NV; i++) begin
      if (i == 1) cmd(5, 0, 0);
      if (i == 2) ld(1, 0);
      if (i == 3) cmd(2, 2, 0);
      tick(); check_state("R6 busy ignore");
    end
    check_state("R5 ready back");

    // R8: restore single after changing wiper
    cmd(1, 1, 0); tick(); ld(0, 1); tick(); check_state("R8 pre restore");
    cmd(3, 1, 0); tick(); check_state("R8 restore one");

    // R7: write protect
    wp = 1;
    ld(1, 0);     tick(); check_state("R7 load blocked");
    cmd(5, 0, 0); tick(); check_state("R7 raise blocked");
    cmd(6, 0, 0); tick(); check_state("R7 lower blocked");
    cmd(1, 3, 1); tick(); check_state("R7 stage allowed");
    cmd(2, 0, 0); tick(); check_state("R7 save blocked");
    cmd(3, 0, 0); tick(); check_state("R8 restore under wp");
    cmd(4, 0, 0); tick(); check_state("R8 restore all under wp");
    wp = 0;
    ld(0, 3); tick(); check_state("R7 staged value loaded");

    // R9: preset overrides load and command, also under wp and busy
    ld(1, 0); tick(); check_state("R9 setup");
    preset = 1; ld(1, 0); cmd(5, 0, 0); tick(); check_state("R9 preset beats load");
    ld(1, 0); tick();
    cmd(2, 3, 0); tick();
    wp = 1; preset = 1; tick(); check_state("R9 preset busy wp");
    wp = 0;
    while (m_busy > 0) tick();
    check_state("R9 idle");

    // R10: reserved, none, and command dropped beside a load
    ld(1, 0); tick();
    cmd(7, 0, 0); tick(); check_state("R10 reserved");
    cmd(0, 0, 0); tick(); check_state("R10 none");
    cmd(4, 0, 0); ld(0, 2); tick(); check_state("R10 cmd dropped with load");
    cmd(5, 0, 0); tick(); check_state("R4 raise after");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule